// File: doc/BRIEF.md
# Program suspend/resume controller

This block is the slice of a NOR-flash command state machine that owns a single program (write) operation and can pause it so that the host may read the array. It receives commands that have already been decoded, each with a full address whose top bits select a bank. It also receives a completion strobe from an abstract program engine. It drives start, hold and resume requests to that engine, a mode code, and a per-bank flag that steers reads of the busy bank to the status word.

A suspend is honoured only while a program runs, and only if it names the bank being programmed. The controller first holds in a pending state for a fixed latency, then enters a suspended read state. In that state only array read, ID read, CFI read and resume are acted on. A resume must name the programming bank, and it is refused while ID or CFI data is being shown. Reads of the exact address being written are marked undefined while the program is paused. If the program began in accelerated mode, the accelerate-hold input must stay high during the whole pause, and a drop sets a sticky fault flag.

Top module: `pgm_pause_ctl`

## Requirements
- R1: A low `rst_n` or a high `hw_reset` at a clock edge returns the controller from any mode to READ and clears `eng_start`, `eng_resume`, `acc_fault` and the bank flags.
- R2: Mode codes are READ=0, WRITE=1, SUSP_PENDING=2, SUSP_READ=3, SUSP_ID=4 and SUSP_CFI=5. Command codes are 0 array read or exit, 1 ID read, 2 CFI read, 3 suspend, 4 resume, 5 program and 6 other. In READ, a program command moves to WRITE, latches its address and pulses `eng_start` for one cycle. In WRITE, `eng_done` returns to READ, and it wins over a suspend in the same cycle.
- R3: A suspend is accepted only in WRITE, and only when its bank field (the top log2(NBANK) address bits) equals that of the latched program address. A suspend in any other case changes nothing.
- R4: After a suspend is accepted the mode is SUSP_PENDING for exactly T_SUSP cycles and then SUSP_READ. `eng_suspend` is high in every mode from SUSP_PENDING to SUSP_CFI. Commands that arrive while pending are discarded.
- R5: In SUSP_READ, an ID command moves to SUSP_ID and a CFI command moves to SUSP_CFI. Program, suspend, other and array-read commands leave the mode unchanged and start nothing.
- R6: In SUSP_ID or SUSP_CFI, only command 0 has an effect, and it returns to SUSP_READ. A resume, or any other command, is ignored there.
- R7: A resume in SUSP_READ whose bank matches the programming bank returns to WRITE, pulses `eng_resume` for one cycle and drops `eng_suspend`. A resume naming another bank is ignored.
- R8: `bank_stat` has only the programming bank's bit set while in WRITE or SUSP_PENDING, and is all zero in every other mode.
- R9: `rd_src` for `rd_addr` is 1 (status) when in WRITE or SUSP_PENDING and the read bank is the programming bank. It is 2 (undefined) in SUSP_READ when `rd_addr` equals the latched program address. It is 3 (ID or CFI data) in SUSP_ID and SUSP_CFI, and 0 (array) otherwise.
- R10: If a program started with `acc_mode` high, then any cycle in modes 2 to 5 with `acc_hold` low sets `acc_fault` at the next edge. The flag stays set until reset.
- R11: In READ, every command other than program is ignored. `eng_done` has no effect outside WRITE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hw_reset | input | 1 | Synchronous hardware reset, active high |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_code | input | 3 | Decoded command code |
| cmd_addr | input | ADDR_W | Command address, bank in the top bits |
| eng_done | input | 1 | Program engine finished |
| acc_mode | input | 1 | Program is issued in accelerated mode |
| acc_hold | input | 1 | Accelerate supply is still held |
| rd_addr | input | ADDR_W | Address of the current read |
| mode | output | 3 | Current mode code |
| eng_start | output | 1 | One-cycle program start request |
| eng_suspend | output | 1 | Hold request to the program engine |
| eng_resume | output | 1 | One-cycle resume request |
| bank_stat | output | NBANK | Per-bank flag: reads return status |
| rd_src | output | 2 | Source of data for `rd_addr` |
| acc_fault | output | 1 | Sticky accelerate-hold violation |

## Verification
Some rules hold in every cycle, and the assertions check those. Pending can only be entered from WRITE, and the pending phase lasts exactly T_SUSP cycles. WRITE can be re-entered from a pause only through SUSP_READ. The start and resume pulses come only from the right modes, and the bank flags are never more than one-hot. The bench's scenarios cover what a property cannot: suspends and resumes addressed to the wrong bank, commands discarded during pending and in the ID and CFI modes, the undefined-read marking, a done strobe in the same cycle as a suspend, and the sticky accelerate fault with its clearing by each reset input.

// File: rtl/pgm_pause_ctl.sv
module pgm_pause_ctl #(
  parameter int NBANK  = 8,
  parameter int ADDR_W = 12,
  parameter int T_SUSP = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_reset,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_code,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              eng_done,
  input  logic              acc_mode,
  input  logic              acc_hold,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [2:0]        mode,
  output logic              eng_start,
  output logic              eng_suspend,
  output logic              eng_resume,
  output logic [NBANK-1:0]  bank_stat,
  output logic [1:0]        rd_src,
  output logic              acc_fault
);
  localparam int BANK_W = $clog2(NBANK);
  localparam int CNT_W  = $clog2(T_SUSP + 1);

  localparam logic [2:0] M_READ = 3'd0, M_WRITE = 3'd1, M_PEND = 3'd2,
                         M_SREAD = 3'd3, M_SID = 3'd4, M_SCFI = 3'd5;
  localparam logic [2:0] C_RD = 3'd0, C_ID = 3'd1, C_CFI = 3'd2,
                         C_SUSP = 3'd3, C_RES = 3'd4, C_PROG = 3'd5;

  logic [2:0]        st, st_nx;
  logic [ADDR_W-1:0] pa;
  logic [CNT_W-1:0]  cnt;
  logic              acc_run;

  wire clr = !rst_n || hw_reset;
  wire [BANK_W-1:0] cbank = cmd_addr[ADDR_W-1 -: BANK_W];
  wire [BANK_W-1:0] pbank = pa[ADDR_W-1 -: BANK_W];
  wire [BANK_W-1:0] rbank = rd_addr[ADDR_W-1 -: BANK_W];
  wire bank_hit = cbank == pbank;
  wire in_susp  = st >= M_PEND;
  wire busy     = st == M_WRITE || st == M_PEND;

  wire go_prog = cmd_valid && cmd_code == C_PROG && st == M_READ;
  wire go_susp = cmd_valid && cmd_code == C_SUSP && bank_hit && st == M_WRITE && !eng_done;
  wire go_res  = cmd_valid && cmd_code == C_RES && bank_hit && st == M_SREAD;

  always_comb begin
    st_nx = st;
    case (st)
      M_READ:  if (go_prog) st_nx = M_WRITE;
      M_WRITE: if (eng_done) st_nx = M_READ;
               else if (go_susp) st_nx = M_PEND;
      M_PEND:  if (cnt == '0) st_nx = M_SREAD;
      M_SREAD: if (go_res) st_nx = M_WRITE;
               else if (cmd_valid && cmd_code == C_ID) st_nx = M_SID;
               else if (cmd_valid && cmd_code == C_CFI) st_nx = M_SCFI;
      M_SID, M_SCFI: if (cmd_valid && cmd_code == C_RD) st_nx = M_SREAD;
      default: st_nx = M_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      st         <= M_READ;
      pa         <= '0;
      cnt        <= '0;
      acc_run    <= 1'b0;
      eng_start  <= 1'b0;
      eng_resume <= 1'b0;
      acc_fault  <= 1'b0;
    end else begin
      st         <= st_nx;
      eng_start  <= go_prog;
      eng_resume <= go_res;
      acc_fault  <= acc_fault | (in_susp & acc_run & !acc_hold);
      if (go_prog) begin
        pa      <= cmd_addr;
        acc_run <= acc_mode;
      end
      if (go_susp) cnt <= CNT_W'(T_SUSP - 1);
      else if (st == M_PEND && cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign mode        = st;
  assign eng_suspend = in_susp;
  assign bank_stat   = busy ? ({{(NBANK-1){1'b0}}, 1'b1} << pbank) : '0;

  always_comb begin
    rd_src = 2'd0;
    if (st == M_SID || st == M_SCFI) rd_src = 2'd3;
    else if (busy && rbank == pbank) rd_src = 2'd1;
    else if (st == M_SREAD && rd_addr == pa) rd_src = 2'd2;
  end
endmodule

module pgm_pause_ctl_chk #(
  parameter int NBANK  = 8,
  parameter int T_SUSP = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hw_reset,
  input logic [2:0]       mode,
  input logic             eng_start,
  input logic             eng_resume,
  input logic [NBANK-1:0] bank_stat
);
  logic [31:0] pend_n;
  always_ff @(posedge clk) begin
    if (!rst_n || hw_reset) pend_n <= '0;
    else if (mode == 3'd2)  pend_n <= pend_n + 1;
    else                    pend_n <= '0;
  end

  AST_SUSP_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n || hw_reset)
    (mode == 3'd2 && $past(mode) != 3'd2) |-> $past(mode) == 3'd1); // R3
  AST_PEND_LEN: assert property (@(posedge clk) disable iff (!rst_n || hw_reset)
    (mode == 3'd3 && $past(mode) == 3'd2) |-> pend_n == T_SUSP); // R4
  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n || hw_reset)
    mode == 3'd2 |-> pend_n < T_SUSP); // R4
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n || hw_reset)
    eng_start |-> ($past(mode) == 3'd0 && mode == 3'd1)); // R2
  AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rst_n || hw_reset)
    eng_resume |-> ($past(mode) == 3'd3 && mode == 3'd1)); // R7
  AST_WRITE_REENTRY: assert property (@(posedge clk) disable iff (!rst_n || hw_reset)
    (mode == 3'd1 && $past(mode) >= 3'd2) |-> $past(mode) == 3'd3); // R6
  AST_STAT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n || hw_reset)
    $onehot0(bank_stat)); // R8
  AST_STAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n || hw_reset)
    (mode == 3'd0 || mode >= 3'd3) |-> bank_stat == '0); // R8
endmodule

bind pgm_pause_ctl pgm_pause_ctl_chk #(.NBANK(NBANK), .T_SUSP(T_SUSP)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_reset(hw_reset), .mode(mode),
  .eng_start(eng_start), .eng_resume(eng_resume), .bank_stat(bank_stat)
);

// File: tb/pgm_pause_ctl_bench.sv
`timescale 1ns/1ps
module pgm_pause_ctl_bench;
  localparam int NB = 8, AW = 12, TS = 5;
  localparam logic [AW-1:0] PA = 12'h2A5, PA_SB = 12'h2A6, PA_OB = 12'h4A5;

  logic clk = 0, rst_n = 0, hw_reset = 0, cmd_valid = 0, eng_done = 0;
  logic acc_mode = 0, acc_hold = 0;
  logic [2:0] cmd_code = 0;
  logic [AW-1:0] cmd_addr = 0, rd_addr = 0;
  logic [2:0] mode;
  logic eng_start, eng_suspend, eng_resume, acc_fault;
  logic [NB-1:0] bank_stat;
  logic [1:0] rd_src;

  int tests = 0, fails = 0;
  bit cmp_en = 0, fin = 0;

  always #5 clk = ~clk;

  pgm_pause_ctl #(.NBANK(NB), .ADDR_W(AW), .T_SUSP(TS)) u_pgm_pause_ctl (
    .clk(clk), .rst_n(rst_n), .hw_reset(hw_reset), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .eng_done(eng_done),
    .acc_mode(acc_mode), .acc_hold(acc_hold), .rd_addr(rd_addr), .mode(mode),
    .eng_start(eng_start), .eng_suspend(eng_suspend), .eng_resume(eng_resume),
    .bank_stat(bank_stat), .rd_src(rd_src), .acc_fault(acc_fault));

  // reference model
  int m_mode = 0, m_wait = 0, m_start = 0, m_resume = 0, m_fault = 0, m_acc = 0;
  int m_pa = 0;

  function automatic int bnk(int a); return (a >> 9) & 7; endfunction

  always @(posedge clk) begin
    m_start = 0; m_resume = 0;
    if (!rst_n || hw_reset) begin
      m_mode = 0; m_wait = 0; m_fault = 0; m_acc = 0; m_pa = 0;
    end else begin
      if (m_mode >= 2 && m_acc != 0 && !acc_hold) m_fault = 1;
      case (m_mode)
        0: if (cmd_valid && cmd_code == 5) begin
             m_mode = 1; m_pa = int'(cmd_addr); m_acc = int'(acc_mode); m_start = 1;
           end
        1: if (eng_done) m_mode = 0;
           else if (cmd_valid && cmd_code == 3 && bnk(int'(cmd_addr)) == bnk(m_pa)) begin
             m_mode = 2; m_wait = TS;
           end
        2: begin m_wait--; if (m_wait == 0) m_mode = 3; end
        3: if (cmd_valid) begin
             if (cmd_code == 1) m_mode = 4;
             else if (cmd_code == 2) m_mode = 5;
             else if (cmd_code == 4 && bnk(int'(cmd_addr)) == bnk(m_pa)) begin
               m_mode = 1; m_resume = 1;
             end
           end
        default: if (cmd_valid && cmd_code == 0) m_mode = 3;
      endcase
    end
  end

  function automatic int exp_src();
    if (m_mode == 4 || m_mode == 5) return 3;
    if ((m_mode == 1 || m_mode == 2) && bnk(int'(rd_addr)) == bnk(m_pa)) return 1;
    if (m_mode == 3 && int'(rd_addr) == m_pa) return 2;
    return 0;
  endfunction

  task automatic check_eq(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_en) begin
    int st;
    st = (m_mode == 1 || m_mode == 2) ? (1 << bnk(m_pa)) : 0;
    check_eq("R5 mode", int'(mode), m_mode);
    check_eq("R2 eng_start", int'(eng_start), m_start);
    check_eq("R4 eng_suspend", int'(eng_suspend), m_mode >= 2 ? 1 : 0);
    check_eq("R7 eng_resume", int'(eng_resume), m_resume);
    check_eq("R8 bank_stat", int'(bank_stat), st);
    check_eq("R9 rd_src", int'(rd_src), exp_src());
    check_eq("R10 acc_fault", int'(acc_fault), m_fault);
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cmd(logic [2:0] c, logic [AW-1:0] a);
    cmd_valid = 1; cmd_code = c; cmd_addr = a;
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic done_pulse();
    eng_done = 1; @(posedge clk); #1; eng_done = 0;
  endtask

  initial begin
    @(posedge clk); #1; cmp_en = 1;
    idle(2);
    check_eq("R1 reset mode", int'(mode), 0);
    rst_n = 1;
    idle(1);

    // R11: commands other than program in READ, and stray done
    cmd(3, PA); cmd(4, PA); cmd(1, PA); cmd(6, PA); done_pulse();
    check_eq("R11 read ignores", int'(mode), 0);

    // R2: program, wrong-bank suspend (R3), status reads, done
    rd_addr = PA_SB;
    cmd(5, PA);
    check_eq("R2 enter write", int'(mode), 1);
    cmd(3, PA_OB);
    check_eq("R3 wrong bank suspend", int'(mode), 1);
    rd_addr = PA_OB; idle(1);
    check_eq("R9 other bank array", int'(rd_src), 0);
    done_pulse();
    check_eq("R2 done to read", int'(mode), 0);

    // suspend flow
    cmd(5, PA);
    rd_addr = PA;
    cmd(3, PA);
    check_eq("R4 pending", int'(mode), 2);
    cmd(1, PA);
    check_eq("R4 pending discards", int'(mode), 2);
    idle(TS - 2);
    check_eq("R4 still pending", int'(mode), 2);
    idle(1);
    check_eq("R4 suspend read", int'(mode), 3);
    check_eq("R9 undefined", int'(rd_src), 2);
    rd_addr = PA_SB; idle(1);
    check_eq("R9 same bank array", int'(rd_src), 0);
    cmd(5, PA_OB);
    check_eq("R5 program ignored", int'(eng_start), 0);
    cmd(6, PA); cmd(3, PA); cmd(0, PA); done_pulse();
    check_eq("R5 others ignored", int'(mode), 3);
    cmd(4, PA_OB);
    check_eq("R7 wrong bank resume", int'(mode), 3);
    cmd(1, PA);
    check_eq("R5 id", int'(mode), 4);
    cmd(4, PA);
    check_eq("R6 resume in id ignored", int'(mode), 4);
    cmd(2, PA);
    check_eq("R6 cfi in id ignored", int'(mode), 4);
    cmd(0, PA);
    check_eq("R6 exit id", int'(mode), 3);
    cmd(2, PA);
    check_eq("R5 cfi", int'(mode), 5);
    cmd(4, PA);
    check_eq("R6 resume in cfi ignored", int'(mode), 5);
    cmd(0, PA);
    cmd(4, PA);
    check_eq("R7 resumed", int'(mode), 1);
    check_eq("R7 resume pulse", int'(eng_resume), 1);
    done_pulse();

    // done beats suspend in the same cycle
    cmd(5, PA);
    eng_done = 1; cmd(3, PA); eng_done = 0;
    check_eq("R2 done wins", int'(mode), 0);

    // accelerated program, hold dropped during pause
    acc_mode = 1; acc_hold = 1;
    cmd(5, PA_OB); acc_mode = 0;
    cmd(3, PA_OB);
    idle(TS + 1);
    check_eq("R10 no fault yet", int'(acc_fault), 0);
    acc_hold = 0; idle(1); acc_hold = 1; idle(2);
    check_eq("R10 fault sticky", int'(acc_fault), 1);
    hw_reset = 1; idle(1); hw_reset = 0;
    check_eq("R1 hw_reset", int'(mode), 0);
    check_eq("R1 fault cleared", int'(acc_fault), 0);

    // reset from SUSP_ID
    cmd(5, PA); cmd(3, PA); idle(TS); cmd(1, PA);
    check_eq("R5 id again", int'(mode), 4);
    rst_n = 0; idle(1); rst_n = 1;
    check_eq("R1 rst_n", int'(mode), 0);
    idle(3);

    fin = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!fin) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule